// File: doc/BRIEF.md
# SD Command Issue Sequencer

This block decides when a host controller may put a new command on the SD command line, and how that command's end is reported. Software loads a command argument and then writes a transfer word holding the command index, the expected response kind, a data-present flag and a command kind. The write of the transfer word arms the sequencer. A start pulse goes to the command serialiser once the card bus is quiet and a minimum idle spacing since the previous command has passed. The serialiser is a separate block.

After launch the sequencer waits for the serialiser to report a received response, a response timeout or a response error. A command whose response signals busy and that has no data phase is not reported complete until the DAT0 line returns high. A bounded wait protects this step. Errors raise sticky status bits and start self-clearing reset requests for the command line or the data line. The command-inhibit flag stays asserted while a command-line reset runs. All status bits are write-one-to-clear.

Top module: `sdcmd_issue_seq`

## Requirements
- R1: A command armed by a transfer-word write starts (`cmd_start_o` high for one cycle) only in a cycle where `cmd_inh_i` and `dat_inh_i` are both low and neither `cmd_rst_o` nor `dat_rst_o` is high. If all conditions already hold, the start comes in the cycle after the write.
- R2: A command also does not start while `dla_i` is high. It starts in the same cycle that `dla_i` falls, provided the other conditions of R1 and R3 hold.
- R3: If the previous command ended in cycle E (the cycle its ending pulse or busy release was seen), the next start is no earlier than cycle E+GAP_CYCLES+1. After reset the first command is not delayed by this spacing.
- R4: A transfer-word write is accepted only while no command is armed or in flight. Later writes are ignored and cause no start. `cmd_word_o` and `cmd_arg_o` hold the accepted word and the argument register value as of the accepting write; argument writes after that do not change `cmd_arg_o`.
- R5: The transfer word is laid out as [10:9] command kind, [8] data present, [7:6] response kind, [5:0] index. Command kind 2'b11 marks an abort, and `cmd_abort_o` is high together with `cmd_start_o` for such a command only.
- R6: While waiting for a response, `rsp_ok_i` sets status bit 0 (done) in the next cycle. `rsp_tout_i` sets bit 1. `rsp_err_i` sets bit 2. The timeout takes priority over the error, and the error takes priority over success. Bits 1 and 2 also start a command-line reset.
- R7: Response kind 2'b11 (short with busy) with the data-present bit clear delays bit 0 until `dat0_i` is seen high after the response. With the data-present bit set, bit 0 follows the response at once.
- R8: If `dat0_i` stays low for BUSY_LIMIT cycles after such a response, status bit 3 (busy timeout) is set in cycle E+BUSY_LIMIT+1, where E is the response cycle. A command-line reset starts in the same cycle, and bit 0 stays clear.
- R9: A command-line reset holds `cmd_rst_o` high for exactly RST_CYCLES cycles, starting the cycle after the error, and then clears itself. `inhibit_cmd_o` is high throughout.
- R10: A `dat_err_i` pulse in any state sets status bit 4 and holds `dat_rst_o` high for exactly RST_CYCLES cycles, without touching `cmd_rst_o`.
- R11: `stat_clr_i` clears the status bits whose mask bits are one. An all-ones mask clears every bit. Bits are otherwise sticky, and a bit set in the same cycle as its clear stays set.
- R12: After reset the status is zero, no reset request or start is active, and `inhibit_cmd_o` follows `cmd_inh_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arg_wr_i | input | 1 | Argument register write strobe |
| arg_data_i | input | ARG_W | Argument write data |
| xfer_wr_i | input | 1 | Transfer-word write strobe; arms a command |
| xfer_data_i | input | 11 | Transfer word (layout in R5) |
| cmd_inh_i | input | 1 | Command line inhibited |
| dat_inh_i | input | 1 | Data lines inhibited |
| dla_i | input | 1 | Data line active |
| dat0_i | input | 1 | Sampled DAT0 level |
| rsp_ok_i | input | 1 | Response received pulse |
| rsp_tout_i | input | 1 | Response timeout pulse |
| rsp_err_i | input | 1 | Response error pulse (CRC, index or end bit) |
| dat_err_i | input | 1 | Data error pulse |
| stat_clr_i | input | 1 | Status write-one-to-clear strobe |
| stat_clr_mask_i | input | 5 | Bits to clear |
| cmd_start_o | output | 1 | Launch pulse to the serialiser |
| cmd_abort_o | output | 1 | Launched command is an abort |
| cmd_arg_o | output | ARG_W | Argument of the armed command |
| cmd_word_o | output | 11 | Transfer word of the armed command |
| stat_o | output | 5 | Status: done, resp timeout, resp error, busy timeout, data error |
| cmd_rst_o | output | 1 | Command-line reset request |
| dat_rst_o | output | 1 | Data-line reset request |
| inhibit_cmd_o | output | 1 | Command inhibit as seen by software |

## Verification
The launch gate is tried with each bus condition held alone: command inhibit, data inhibit, data-line-active, and a running line reset. Each one alone must hold back an armed command, which shows that no single condition is left out of the gate. Back-to-back commands measure the exact start cycle against the end of the previous command, which separates a correct spacing from one that is a cycle short or counts from the start instead. The three response kinds that matter are run separately: a plain short response, a busy response with no data that is released by DAT0 or runs into the limit, and a busy response with data that must not wait. Together they show that the busy wait depends on both fields of the word. Argument writes and transfer-word writes made while a command is armed or in flight show that only the accepted values reach the serialiser.

// File: rtl/sdq_pkg.sv
package sdq_pkg;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'b00,
        RSP_LONG  = 2'b01,
        RSP_SHORT = 2'b10,
        RSP_BUSY  = 2'b11
    } rsp_kind_e;

    typedef enum logic [1:0] {
        CK_NORMAL  = 2'b00,
        CK_SUSPEND = 2'b01,
        CK_RESUME  = 2'b10,
        CK_ABORT   = 2'b11
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e  kind;
        logic       has_data;
        rsp_kind_e  rsp;
        logic [5:0] index;
    } xfer_word_t;

    localparam int XFER_W = $bits(xfer_word_t);

    localparam int ST_DONE  = 0;
    localparam int ST_RTOUT = 1;
    localparam int ST_RERR  = 2;
    localparam int ST_BTOUT = 3;
    localparam int ST_DERR  = 4;
    localparam int ST_W     = 5;

    localparam int LN_CMD = 0;
    localparam int LN_DAT = 1;
    localparam int LN_N   = 2;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'b00,
        SQ_ARMED = 2'b01,
        SQ_RESP  = 2'b10,
        SQ_BUSY  = 2'b11
    } seq_state_e;

    function automatic logic needs_busy_wait(input xfer_word_t w);
        return (w.rsp == RSP_BUSY) && !w.has_data;
    endfunction

    function automatic logic is_abort(input xfer_word_t w);
        return w.kind == CK_ABORT;
    endfunction

endpackage

// File: rtl/sdq_gap_timer.sv
module sdq_gap_timer #(
    parameter int GAP = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic end_i,
    output logic ok_o
);
    localparam int CW = $clog2(GAP + 1);
    localparam logic [CW-1:0] GAP_C = CW'(GAP);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= GAP_C;
        end else if (end_i) begin
            cnt_q <= '0;
        end else if (cnt_q != GAP_C) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ok_o = (cnt_q == GAP_C);
endmodule

// File: rtl/sdq_busy_timer.sv
module sdq_busy_timer #(
    parameter int LIMIT = 30_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST_C = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !active_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST_C) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = active_i && (cnt_q == LAST_C);
endmodule

// File: rtl/sdq_line_reset.sv
module sdq_line_reset #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic active_o
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] CYC_C = CW'(CYCLES);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (start_i) begin
            left_q <= CYC_C;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign active_o = (left_q != '0);
endmodule

// File: rtl/sdq_status.sv
module sdq_status #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_wr_i,
    input  logic [W-1:0] clr_mask_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] stat_q;
    logic [W-1:0] keep;

    assign keep = clr_wr_i ? ~clr_mask_i : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & keep) | set_i;
        end
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/sdcmd_issue_seq.sv
module sdcmd_issue_seq
    import sdq_pkg::*;
#(
    parameter int ARG_W      = 32,
    parameter int GAP_CYCLES = 8,
    parameter int BUSY_LIMIT = 30_000_000,
    parameter int RST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arg_wr_i,
    input  logic [ARG_W-1:0]  arg_data_i,
    input  logic              xfer_wr_i,
    input  logic [XFER_W-1:0] xfer_data_i,
    input  logic              cmd_inh_i,
    input  logic              dat_inh_i,
    input  logic              dla_i,
    input  logic              dat0_i,
    input  logic              rsp_ok_i,
    input  logic              rsp_tout_i,
    input  logic              rsp_err_i,
    input  logic              dat_err_i,
    input  logic              stat_clr_i,
    input  logic [ST_W-1:0]   stat_clr_mask_i,
    output logic              cmd_start_o,
    output logic              cmd_abort_o,
    output logic [ARG_W-1:0]  cmd_arg_o,
    output logic [XFER_W-1:0] cmd_word_o,
    output logic [ST_W-1:0]   stat_o,
    output logic              cmd_rst_o,
    output logic              dat_rst_o,
    output logic              inhibit_cmd_o
);
    seq_state_e  state_q, state_d;
    xfer_word_t  word_q;
    logic [ARG_W-1:0] arg_q, arg_snap_q;

    logic [ST_W-1:0] stat_set;
    logic [LN_N-1:0] line_req, line_act;
    logic cmd_end, gap_ok, busy_expired, launch_ok, start;

    // Spacing since the previous command's end
    sdq_gap_timer #(.GAP(GAP_CYCLES)) u_gap (
        .clk   (clk),
        .rst   (rst),
        .end_i (cmd_end),
        .ok_o  (gap_ok)
    );

    // Bounded wait for DAT0 release
    sdq_busy_timer #(.LIMIT(BUSY_LIMIT)) u_busy (
        .clk       (clk),
        .rst       (rst),
        .active_i  (state_q == SQ_BUSY),
        .expired_o (busy_expired)
    );

    // One self-clearing reset request per line
    for (genvar g = 0; g < LN_N; g++) begin : g_line
        sdq_line_reset #(.CYCLES(RST_CYCLES)) u_line (
            .clk      (clk),
            .rst      (rst),
            .start_i  (line_req[g]),
            .active_o (line_act[g])
        );
    end

    sdq_status #(.W(ST_W)) u_stat (
        .clk        (clk),
        .rst        (rst),
        .set_i      (stat_set),
        .clr_wr_i   (stat_clr_i),
        .clr_mask_i (stat_clr_mask_i),
        .stat_o     (stat_o)
    );

    assign launch_ok = !cmd_inh_i && !dat_inh_i && !dla_i &&
                       !line_act[LN_CMD] && !line_act[LN_DAT] && gap_ok;

    always_comb begin
        state_d  = state_q;
        stat_set = '0;
        line_req = '0;
        cmd_end  = 1'b0;
        start    = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (xfer_wr_i) state_d = SQ_ARMED;
            end
            SQ_ARMED: begin
                if (launch_ok) begin
                    start   = 1'b1;
                    state_d = SQ_RESP;
                end
            end
            SQ_RESP: begin
                if (rsp_tout_i) begin
                    stat_set[ST_RTOUT] = 1'b1;
                    line_req[LN_CMD]   = 1'b1;
                    cmd_end            = 1'b1;
                    state_d            = SQ_IDLE;
                end else if (rsp_err_i) begin
                    stat_set[ST_RERR]  = 1'b1;
                    line_req[LN_CMD]   = 1'b1;
                    cmd_end            = 1'b1;
                    state_d            = SQ_IDLE;
                end else if (rsp_ok_i) begin
                    if (needs_busy_wait(word_q)) begin
                        state_d = SQ_BUSY;
                    end else begin
                        stat_set[ST_DONE] = 1'b1;
                        cmd_end           = 1'b1;
                        state_d           = SQ_IDLE;
                    end
                end
            end
            SQ_BUSY: begin
                if (dat0_i) begin
                    stat_set[ST_DONE] = 1'b1;
                    cmd_end           = 1'b1;
                    state_d           = SQ_IDLE;
                end else if (busy_expired) begin
                    stat_set[ST_BTOUT] = 1'b1;
                    line_req[LN_CMD]   = 1'b1;
                    cmd_end            = 1'b1;
                    state_d            = SQ_IDLE;
                end
            end
            default: state_d = SQ_IDLE;
        endcase
        if (dat_err_i) begin
            stat_set[ST_DERR] = 1'b1;
            line_req[LN_DAT]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SQ_IDLE;
            word_q     <= '0;
            arg_q      <= '0;
            arg_snap_q <= '0;
        end else begin
            state_q <= state_d;
            if (arg_wr_i) arg_q <= arg_data_i;
            if (state_q == SQ_IDLE && xfer_wr_i) begin
                word_q     <= xfer_word_t'(xfer_data_i);
                arg_snap_q <= arg_q;
            end
        end
    end

    assign cmd_start_o   = start;
    assign cmd_abort_o   = start && is_abort(word_q);
    assign cmd_arg_o     = arg_snap_q;
    assign cmd_word_o    = word_q;
    assign cmd_rst_o     = line_act[LN_CMD];
    assign dat_rst_o     = line_act[LN_DAT];
    assign inhibit_cmd_o = cmd_inh_i || line_act[LN_CMD] || (state_q != SQ_IDLE);

endmodule

// File: rtl/sdq_checker.sv
module sdq_checker #(
    parameter int GAP_CYCLES = 8,
    parameter int RST_CYCLES = 8,
    parameter int ST_W       = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            cmd_start_o,
    input logic            cmd_abort_o,
    input logic            cmd_rst_o,
    input logic            dat_rst_o,
    input logic            inhibit_cmd_o,
    input logic            cmd_inh_i,
    input logic            dat_inh_i,
    input logic            dla_i,
    input logic            stat_clr_i,
    input logic [ST_W-1:0] stat_o
);
    localparam int GW = $clog2(GAP_CYCLES + 3) + 1;
    localparam logic [GW-1:0] GMIN = GW'(GAP_CYCLES + 2);
    localparam int RW = $clog2(RST_CYCLES + 2) + 1;
    localparam logic [RW-1:0] RMAX = RW'(RST_CYCLES);

    logic [GW-1:0] since_start;
    logic [RW-1:0] crun, drun;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_start <= GMIN;
            crun        <= '0;
            drun        <= '0;
        end else begin
            if (cmd_start_o)            since_start <= GW'(1);
            else if (since_start != GMIN) since_start <= since_start + 1'b1;
            crun <= cmd_rst_o ? ((crun == RMAX + 1'b1) ? crun : crun + 1'b1) : '0;
            drun <= dat_rst_o ? ((drun == RMAX + 1'b1) ? drun : drun + 1'b1) : '0;
        end
    end

    AST_START_NO_INHIBIT: assert property (@(posedge clk) disable iff (rst)
        cmd_start_o |-> (!cmd_inh_i && !dat_inh_i)); // R1
    AST_START_NO_DLA: assert property (@(posedge clk) disable iff (rst)
        cmd_start_o |-> !dla_i); // R2
    AST_START_SPACING: assert property (@(posedge clk) disable iff (rst)
        cmd_start_o |-> (since_start >= GMIN)); // R3
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cmd_start_o |=> !cmd_start_o); // R4
    AST_ABORT_WITH_START: assert property (@(posedge clk) disable iff (rst)
        cmd_abort_o |-> cmd_start_o); // R5
    AST_NO_START_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        cmd_start_o |-> (!cmd_rst_o && !dat_rst_o)); // R1
    AST_RESET_HOLDS_INHIBIT: assert property (@(posedge clk) disable iff (rst)
        cmd_rst_o |-> inhibit_cmd_o); // R9
    AST_CMD_RESET_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        crun <= RMAX); // R9
    AST_DAT_RESET_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        drun <= RMAX); // R10
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !stat_clr_i |=> ((stat_o & $past(stat_o)) == $past(stat_o))); // R11

endmodule

bind sdcmd_issue_seq sdq_checker #(
    .GAP_CYCLES (GAP_CYCLES),
    .RST_CYCLES (RST_CYCLES),
    .ST_W       (sdq_pkg::ST_W)
) u_sdq_checker (
    .clk           (clk),
    .rst           (rst),
    .cmd_start_o   (cmd_start_o),
    .cmd_abort_o   (cmd_abort_o),
    .cmd_rst_o     (cmd_rst_o),
    .dat_rst_o     (dat_rst_o),
    .inhibit_cmd_o (inhibit_cmd_o),
    .cmd_inh_i     (cmd_inh_i),
    .dat_inh_i     (dat_inh_i),
    .dla_i         (dla_i),
    .stat_clr_i    (stat_clr_i),
    .stat_o        (stat_o)
);

// File: tb/sdcmd_issue_seq_bench.sv
module sdcmd_issue_seq_bench;
    import sdq_pkg::*;

    localparam int ARG_W = 32;
    localparam int GAP   = 8;
    localparam int LIMIT = 40;
    localparam int RSTC  = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arg_wr_i = 0, xfer_wr_i = 0;
    logic [ARG_W-1:0] arg_data_i = '0;
    logic [XFER_W-1:0] xfer_data_i = '0;
    logic cmd_inh_i = 0, dat_inh_i = 0, dla_i = 0, dat0_i = 1;
    logic rsp_ok_i = 0, rsp_tout_i = 0, rsp_err_i = 0, dat_err_i = 0;
    logic stat_clr_i = 0;
    logic [ST_W-1:0] stat_clr_mask_i = '0;
    logic cmd_start_o, cmd_abort_o, cmd_rst_o, dat_rst_o, inhibit_cmd_o;
    logic [ARG_W-1:0] cmd_arg_o;
    logic [XFER_W-1:0] cmd_word_o;
    logic [ST_W-1:0] stat_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdcmd_issue_seq #(
        .ARG_W(ARG_W), .GAP_CYCLES(GAP), .BUSY_LIMIT(LIMIT), .RST_CYCLES(RSTC)
    ) u_sdcmd_issue_seq (
        .clk(clk), .rst(rst), .arg_wr_i(arg_wr_i), .arg_data_i(arg_data_i),
        .xfer_wr_i(xfer_wr_i), .xfer_data_i(xfer_data_i),
        .cmd_inh_i(cmd_inh_i), .dat_inh_i(dat_inh_i), .dla_i(dla_i), .dat0_i(dat0_i),
        .rsp_ok_i(rsp_ok_i), .rsp_tout_i(rsp_tout_i), .rsp_err_i(rsp_err_i),
        .dat_err_i(dat_err_i), .stat_clr_i(stat_clr_i), .stat_clr_mask_i(stat_clr_mask_i),
        .cmd_start_o(cmd_start_o), .cmd_abort_o(cmd_abort_o), .cmd_arg_o(cmd_arg_o),
        .cmd_word_o(cmd_word_o), .stat_o(stat_o), .cmd_rst_o(cmd_rst_o),
        .dat_rst_o(dat_rst_o), .inhibit_cmd_o(inhibit_cmd_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [XFER_W-1:0] mk(input cmd_kind_e k, input logic d,
                                             input rsp_kind_e r, input logic [5:0] idx);
        xfer_word_t w;
        w.kind = k; w.has_data = d; w.rsp = r; w.index = idx;
        return w;
    endfunction

    task automatic write_arg(input logic [ARG_W-1:0] v);
        @(negedge clk); arg_wr_i = 1; arg_data_i = v;
        @(negedge clk); arg_wr_i = 0;
    endtask

    task automatic write_xfer(input logic [XFER_W-1:0] w);
        @(negedge clk); xfer_wr_i = 1; xfer_data_i = w;
        @(negedge clk); xfer_wr_i = 0;
    endtask

    task automatic wait_start(input string req, output int sc);
        int n = 0;
        #1;
        while (!cmd_start_o && n < 300) begin
            @(negedge clk); #1; n++;
        end
        sc = cyc;
        chk(req, cmd_start_o, 1'b1);
    endtask

    task automatic pulse_ok(output int ec);
        @(negedge clk); rsp_ok_i = 1; ec = cyc;
        @(negedge clk); rsp_ok_i = 0; #1;
    endtask

    task automatic settle();
        int n = 0;
        #1;
        while ((cmd_rst_o || dat_rst_o) && n < 100) begin
            @(negedge clk); #1; n++;
        end
        @(negedge clk); stat_clr_i = 1; stat_clr_mask_i = '1;
        @(negedge clk); stat_clr_i = 0; stat_clr_mask_i = '0;
        repeat (GAP + 2) @(negedge clk);
    endtask

    task automatic count_high(input bit sel_dat, output int n);
        n = 0;
        while ((sel_dat ? dat_rst_o : cmd_rst_o) && n < 100) begin
            n++; @(negedge clk); #1;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk); #1;
        chk("R12 status", stat_o, '0);
        chk("R12 resets", {cmd_rst_o, dat_rst_o, cmd_start_o}, 3'b000);
        chk("R12 inhibit", inhibit_cmd_o, 1'b0);
    endtask

    task automatic t_basic();
        int sc, ec;
        write_arg(32'hA5A5_0001);
        write_xfer(mk(CK_NORMAL, 0, RSP_SHORT, 6'd17));
        wait_start("R1 first launch", sc);
        chk("R4 word", cmd_word_o, mk(CK_NORMAL, 0, RSP_SHORT, 6'd17));
        chk("R4 arg", cmd_arg_o, 32'hA5A5_0001);
        chk("R5 normal not abort", cmd_abort_o, 1'b0);
        chk("R6 not done early", stat_o[ST_DONE], 1'b0);
        pulse_ok(ec);
        chk("R6 done", stat_o, 5'b00001);
        settle();
    endtask

    task automatic t_gap();
        int sc, ec, sc2;
        write_xfer(mk(CK_NORMAL, 0, RSP_SHORT, 6'd13));
        wait_start("R3 launch", sc);
        pulse_ok(ec);
        write_xfer(mk(CK_NORMAL, 0, RSP_SHORT, 6'd18));
        wait_start("R3 second launch", sc2);
        chk("R3 spacing", sc2 - ec, GAP + 1);
        pulse_ok(ec);
        settle();
    endtask

    task automatic t_gate();
        int sc, ec, ns = 0;
        write_arg(32'h0000_1234);
        cmd_inh_i = 1;
        write_xfer(mk(CK_NORMAL, 0, RSP_SHORT, 6'd7));
        repeat (5) begin @(negedge clk); #1; if (cmd_start_o) ns++; end
        write_arg(32'hDEAD_BEEF);
        @(negedge clk); cmd_inh_i = 0; dat_inh_i = 1;
        repeat (5) begin #1; if (cmd_start_o) ns++; @(negedge clk); end
        dat_inh_i = 0; dla_i = 1;
        repeat (5) begin #1; if (cmd_start_o) ns++; @(negedge clk); end
        chk("R1 held by inhibits", ns, 0);
        dla_i = 0; #1;
        chk("R2 start as dla falls", cmd_start_o, 1'b1);
        chk("R4 arg snapshot", cmd_arg_o, 32'h0000_1234);
        pulse_ok(ec);
        settle();
    endtask

    task automatic t_ignore();
        int sc, ec, ns = 0;
        write_xfer(mk(CK_NORMAL, 0, RSP_SHORT, 6'd9));
        wait_start("R4 launch", sc);
        write_xfer(mk(CK_NORMAL, 0, RSP_SHORT, 6'd33));
        pulse_ok(ec);
        repeat (20) begin @(negedge clk); #1; if (cmd_start_o) ns++; end
        chk("R4 late write no start", ns, 0);
        chk("R4 word kept", cmd_word_o, mk(CK_NORMAL, 0, RSP_SHORT, 6'd9));
        settle();
    endtask

    task automatic t_abort();
        int sc, ec;
        write_xfer(mk(CK_ABORT, 0, RSP_BUSY, 6'd12));
        wait_start("R5 launch", sc);
        chk("R5 abort flag", cmd_abort_o, 1'b1);
        pulse_ok(ec);
        settle();
    endtask

    task automatic t_busy();
        int sc, ec;
        dat0_i = 0;
        write_xfer(mk(CK_NORMAL, 0, RSP_BUSY, 6'd7));
        wait_start("R7 launch", sc);
        pulse_ok(ec);
        repeat (5) @(negedge clk);
        #1;
        chk("R7 held while DAT0 low", stat_o[ST_DONE], 1'b0);
        @(negedge clk); dat0_i = 1;
        @(negedge clk); #1;
        chk("R7 done after DAT0 high", stat_o, 5'b00001);
        settle();
        dat0_i = 0;
        write_xfer(mk(CK_NORMAL, 1, RSP_BUSY, 6'd25));
        wait_start("R7 data launch", sc);
        pulse_ok(ec);
        chk("R7 data phase no wait", stat_o[ST_DONE], 1'b1);
        dat0_i = 1;
        settle();
    endtask

    task automatic t_busy_timeout();
        int sc, ec, n = 0, nh;
        dat0_i = 0;
        write_xfer(mk(CK_NORMAL, 0, RSP_BUSY, 6'd38));
        wait_start("R8 launch", sc);
        @(negedge clk); rsp_ok_i = 1; ec = cyc;
        @(negedge clk); rsp_ok_i = 0; #1;
        while (!stat_o[ST_BTOUT] && n < 200) begin @(negedge clk); #1; n++; end
        chk("R8 expiry cycle", cyc - ec, LIMIT + 1);
        chk("R8 no done", stat_o[ST_DONE], 1'b0);
        chk("R8 cmd reset", cmd_rst_o, 1'b1);
        chk("R9 inhibit in reset", inhibit_cmd_o, 1'b1);
        count_high(1'b0, nh);
        chk("R9 cmd reset length", nh, RSTC);
        dat0_i = 1;
        settle();
    endtask

    task automatic t_errors();
        int sc, ec, sc2, nh;
        write_xfer(mk(CK_NORMAL, 0, RSP_LONG, 6'd2));
        wait_start("R6 launch", sc);
        @(negedge clk); rsp_tout_i = 1; rsp_err_i = 1; ec = cyc;
        @(negedge clk); rsp_tout_i = 0; rsp_err_i = 0; #1;
        chk("R6 timeout wins", stat_o, 5'b00010);
        chk("R9 reset on timeout", {cmd_rst_o, inhibit_cmd_o, dat_rst_o}, 3'b110);
        write_xfer(mk(CK_NORMAL, 0, RSP_SHORT, 6'd3));
        wait_start("R9 launch after reset", sc2);
        chk("R9 held by reset", sc2 - ec, RSTC + 1);
        @(negedge clk); rsp_err_i = 1;
        @(negedge clk); rsp_err_i = 0; #1;
        chk("R6 error bit", stat_o[ST_RERR], 1'b1);
        chk("R6 error resets line", cmd_rst_o, 1'b1);
        count_high(1'b0, nh);
        chk("R9 length after error", nh, RSTC);
        settle();
    endtask

    task automatic t_data_err();
        int nh;
        @(negedge clk); dat_err_i = 1;
        @(negedge clk); dat_err_i = 0; #1;
        chk("R10 data error bit", stat_o, 5'b10000);
        chk("R10 only data reset", {dat_rst_o, cmd_rst_o}, 2'b10);
        count_high(1'b1, nh);
        chk("R10 data reset length", nh, RSTC);
    endtask

    task automatic t_w1c();
        @(negedge clk); dat_err_i = 1; rsp_tout_i = 0;
        @(negedge clk); dat_err_i = 0;
        write_xfer(mk(CK_NORMAL, 0, RSP_SHORT, 6'd1));
        begin int sc, ec; wait_start("R11 launch", sc); pulse_ok(ec); end
        chk("R11 two bits pending", stat_o, 5'b10001);
        @(negedge clk); stat_clr_i = 1; stat_clr_mask_i = 5'b10000;
        @(negedge clk); stat_clr_i = 0; #1;
        chk("R11 masked clear", stat_o, 5'b00001);
        @(negedge clk); stat_clr_i = 1; stat_clr_mask_i = '1; dat_err_i = 1;
        @(negedge clk); stat_clr_i = 0; dat_err_i = 0; #1;
        chk("R11 set wins over clear", stat_o, 5'b10000);
        @(negedge clk); stat_clr_i = 1; stat_clr_mask_i = '1;
        @(negedge clk); stat_clr_i = 0; #1;
        chk("R11 all ones clears", stat_o, 5'b00000);
        settle();
    endtask

    initial begin
        t_reset();
        t_basic();
        t_gap();
        t_gate();
        t_ignore();
        t_abort();
        t_busy();
        t_busy_timeout();
        t_errors();
        t_data_err();
        t_w1c();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule